// File: doc/BRIEF.md
# Dual-Bank LCD Segment Memory

This block stores the per-segment state of a multiplexed LCD panel: one bit for every crossing of a frontplane and a backplane. It holds two banks of identical shape. One says whether each segment is lit. The other says whether each segment takes part in blinking. The CPU reaches both banks through one small byte-wide window, and a bank-select input decides which bank that window addresses at any moment.

On the display side, both banks are presented in full as flat parallel vectors. The waveform generator can therefore sample any segment at any time without arbitrating against CPU traffic. The block also provides a one-cycle clear command that zeroes only the bank currently selected. When the module enable is low, the window is ordinary read/write storage, and toggling that enable never disturbs what is stored. Storage has no reset, so its contents are undefined until software writes them.

Top module: `lcd_seg_mem`

## Requirements
- R1: With `bank_sel_i` = 0, a write at address a stores `wdata_i` into the on/off bank. Bit n of that byte is backplane n of frontplane a and appears at `seg_on_o[a*NUM_BP + n]`.
- R2: With `bank_sel_i` = 1, a write at address a stores `wdata_i` into the blink-enable bank. Bit n appears at `blink_en_o[a*NUM_BP + n]`.
- R3: A write to one bank leaves every bit of the other bank unchanged.
- R4: `rdata_o` shows, in the same cycle and without a clock edge, the byte at `addr_i` of the bank chosen by `bank_sel_i`.
- R5: Sampling `clear_i` = 1 on a clock edge zeroes every bit of the selected bank on that edge. The unselected bank is left unchanged.
- R6: If `wr_en_i` and `clear_i` are both high on the same edge, the clear wins and the written byte is lost.
- R7: `seg_active_o[a*NUM_BP + n]` is 1 exactly when the on/off bit for that segment is 1, `fp_en_i[a]` is 1 and `mod_en_i` is 1. `fp_drive_o[a]` equals `fp_en_i[a]` AND `mod_en_i`.
- R8: While `mod_en_i` = 0, both banks remain writable and readable as plain storage. Changing `mod_en_i` alters no stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (does not reach the storage) |
| bank_sel_i | input | 1 | 0: on/off bank, 1: blink-enable bank |
| addr_i | input | AW | Frontplane address (byte index) |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | NUM_BP | Write byte, bit n = backplane n |
| rdata_o | output | NUM_BP | Read byte of the selected bank |
| clear_i | input | 1 | One-cycle clear of the selected bank |
| mod_en_i | input | 1 | Module enable |
| fp_en_i | input | NUM_FP | Per-frontplane enable |
| seg_on_o | output | NUM_FP*NUM_BP | Full on/off bank |
| blink_en_o | output | NUM_FP*NUM_BP | Full blink-enable bank |
| seg_active_o | output | NUM_FP*NUM_BP | Segments to be driven lit |
| fp_drive_o | output | NUM_FP | Effective frontplane enables |

## Verification
Both banks are filled at every address with two different arithmetic byte patterns. A per-address pattern exposes swapped addresses or lanes, and using a different pattern per bank exposes crossed banks. Every byte is read back through the window and through the parallel vectors. The frontplane enable is swept with all-ones, alternating and walking one-hot masks, and the module enable is toggled. Together these separate gating by frontplane from gating by module, and show that the stored data survives both. Each bank is cleared once with a write to the same bank in the same cycle, which shows that the clear takes priority over the write and is confined to the selected bank.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;
  typedef enum logic {
    BANK_ONOFF = 1'b0,
    BANK_BLINK = 1'b1
  } bank_e;

  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/lcd_seg_bank.sv
module lcd_seg_bank #(
  parameter int unsigned NUM_FP = 32,
  parameter int unsigned NUM_BP = 8,
  localparam int unsigned AW = $clog2(NUM_FP),
  localparam int unsigned VW = NUM_FP * NUM_BP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_en_i,
  input  logic              clr_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [NUM_BP-1:0] wdata_i,
  output logic [NUM_BP-1:0] rbyte_o,
  output logic [VW-1:0]     mem_o
);
  logic [NUM_BP-1:0] row_q [NUM_FP];
  logic              clr_hit;
  logic              wr_hit;

  assign clr_hit = sel_i & clr_i;
  assign wr_hit  = sel_i & wr_en_i;

  // No reset on storage: contents undefined until written.
  for (genvar fp = 0; fp < NUM_FP; fp++) begin : g_row
    always_ff @(posedge clk_i) begin
      if (clr_hit) begin
        row_q[fp] <= '0;
      end else if (wr_hit && (addr_i == AW'(fp))) begin
        row_q[fp] <= wdata_i;
      end
    end
    assign mem_o[fp*NUM_BP +: NUM_BP] = row_q[fp];
  end

  assign rbyte_o = row_q[addr_i];

  AST_CLR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_hit |=> (mem_o == '0)); // R5

  AST_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && !clr_i) |=> (rbyte_o == $past(wdata_i) || addr_i != $past(addr_i))); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clr_hit || wr_hit) |=> $stable(mem_o)); // R3
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive #(
  parameter int unsigned NUM_FP = 32,
  parameter int unsigned NUM_BP = 8,
  localparam int unsigned VW = NUM_FP * NUM_BP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mod_en_i,
  input  logic [NUM_FP-1:0] fp_en_i,
  input  logic [VW-1:0]     seg_on_i,
  output logic [VW-1:0]     seg_active_o,
  output logic [NUM_FP-1:0] fp_drive_o
);
  for (genvar fp = 0; fp < NUM_FP; fp++) begin : g_fp
    assign fp_drive_o[fp] = fp_en_i[fp] & mod_en_i;
    assign seg_active_o[fp*NUM_BP +: NUM_BP] =
      seg_on_i[fp*NUM_BP +: NUM_BP] & {NUM_BP{fp_drive_o[fp]}};
  end

  AST_OFF_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_en_i |-> (seg_active_o == '0 && fp_drive_o == '0)); // R7

  AST_ACTIVE_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seg_active_o & ~seg_on_i) == '0)); // R7
endmodule

// File: rtl/lcd_seg_mem.sv
module lcd_seg_mem
  import lcd_seg_pkg::*;
#(
  parameter int unsigned NUM_FP = 32,
  parameter int unsigned NUM_BP = 8,
  localparam int unsigned AW = $clog2(NUM_FP),
  localparam int unsigned VW = NUM_FP * NUM_BP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bank_sel_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_en_i,
  input  logic [NUM_BP-1:0] wdata_i,
  output logic [NUM_BP-1:0] rdata_o,
  input  logic              clear_i,
  input  logic              mod_en_i,
  input  logic [NUM_FP-1:0] fp_en_i,
  output logic [VW-1:0]     seg_on_o,
  output logic [VW-1:0]     blink_en_o,
  output logic [VW-1:0]     seg_active_o,
  output logic [NUM_FP-1:0] fp_drive_o
);
  logic [NUM_BP-1:0] rbyte [NUM_BANKS];
  logic [VW-1:0]     bank_vec [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (bank_sel_i == b[0]);
    lcd_seg_bank #(.NUM_FP(NUM_FP), .NUM_BP(NUM_BP)) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel),
      .wr_en_i (wr_en_i),
      .clr_i   (clear_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .rbyte_o (rbyte[b]),
      .mem_o   (bank_vec[b])
    );
  end

  assign seg_on_o   = bank_vec[BANK_ONOFF];
  assign blink_en_o = bank_vec[BANK_BLINK];
  assign rdata_o    = (bank_e'(bank_sel_i) == BANK_BLINK) ? rbyte[BANK_BLINK]
                                                          : rbyte[BANK_ONOFF];

  lcd_seg_drive #(.NUM_FP(NUM_FP), .NUM_BP(NUM_BP)) u_drive (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mod_en_i     (mod_en_i),
    .fp_en_i      (fp_en_i),
    .seg_on_i     (seg_on_o),
    .seg_active_o (seg_active_o),
    .fp_drive_o   (fp_drive_o)
  );

  AST_BLINK_SPARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_sel_i == BANK_ONOFF) |=> $stable(blink_en_o)); // R3

  AST_ONOFF_SPARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_sel_i == BANK_BLINK) |=> $stable(seg_on_o)); // R5

  AST_EN_NO_TOUCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !clear_i) |=> ($stable(seg_on_o) && $stable(blink_en_o))); // R8
endmodule

// File: tb/lcd_seg_mem_tb.sv
module lcd_seg_mem_tb;
  localparam int NFP = 32;
  localparam int NBP = 8;
  localparam int VW  = NFP * NBP;

  logic clk = 0;
  logic rst_n = 0;
  logic bank_sel = 0, wr_en = 0, clear = 0, mod_en = 0;
  logic [4:0] addr = '0;
  logic [NBP-1:0] wdata = '0;
  logic [NFP-1:0] fp_en = '0;
  logic [NBP-1:0] rdata;
  logic [VW-1:0] seg_on, blink_en, seg_active;
  logic [NFP-1:0] fp_drive;

  int checks = 0, errors = 0;
  logic [NBP-1:0] m_on [NFP];
  logic [NBP-1:0] m_bl [NFP];

  always #4 clk = ~clk;

  lcd_seg_mem #(.NUM_FP(NFP), .NUM_BP(NBP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bank_sel_i(bank_sel), .addr_i(addr),
    .wr_en_i(wr_en), .wdata_i(wdata), .rdata_o(rdata), .clear_i(clear),
    .mod_en_i(mod_en), .fp_en_i(fp_en), .seg_on_o(seg_on),
    .blink_en_o(blink_en), .seg_active_o(seg_active), .fp_drive_o(fp_drive)
  );

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act,
                     input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic b, input int a, input logic [NBP-1:0] d);
    @(negedge clk);
    bank_sel = b; addr = 5'(a); wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    if (b) m_bl[a] = d; else m_on[a] = d;
  endtask

  task automatic do_clear(input logic b, input int a, input logic [NBP-1:0] d);
    @(negedge clk);
    bank_sel = b; addr = 5'(a); wdata = d; wr_en = 1; clear = 1;
    @(negedge clk);
    wr_en = 0; clear = 0;
    for (int i = 0; i < NFP; i++) if (b) m_bl[i] = '0; else m_on[i] = '0;
  endtask

  function automatic logic [VW-1:0] pack(input logic b);
    logic [VW-1:0] v;
    for (int i = 0; i < NFP; i++) v[i*NBP +: NBP] = b ? m_bl[i] : m_on[i];
    return v;
  endfunction

  function automatic logic [VW-1:0] exp_active();
    logic [VW-1:0] v;
    for (int i = 0; i < NFP; i++)
      v[i*NBP +: NBP] = (fp_en[i] && mod_en) ? m_on[i] : '0;
    return v;
  endfunction

  task automatic check_vectors(input string req);
    #1;
    chk(seg_on == pack(0), req, seg_on, pack(0));
    chk(blink_en == pack(1), req, blink_en, pack(1));
  endtask

  task automatic check_reads(input string req);
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < NFP; a++) begin
        @(negedge clk);
        bank_sel = b[0]; addr = 5'(a);
        #1;
        chk(rdata == (b ? m_bl[a] : m_on[a]), req, VW'(rdata),
            VW'(b ? m_bl[a] : m_on[a]));
      end
  endtask

  task automatic check_drive(input string req);
    #1;
    chk(seg_active == exp_active(), req, seg_active, exp_active());
    chk(fp_drive == (fp_en & {NFP{mod_en}}), req, VW'(fp_drive),
        VW'(fp_en & {NFP{mod_en}}));
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state: module disabled, nothing driven
    #1;
    chk(fp_drive == '0, "R7 reset", VW'(fp_drive), '0);
    chk(seg_active == '0, "R7 reset", seg_active, '0);
    rst_n = 1;

    // R8 storage usable with mod_en low; R1/R2 per-bank patterns
    for (int a = 0; a < NFP; a++) wr(0, a, 8'((a * 29 + 7) & 8'hff));
    for (int a = 0; a < NFP; a++) wr(1, a, ~8'((a * 13 + 3) & 8'hff));
    check_vectors("R1/R2 fill");
    check_reads("R4 R8 readback");

    // R3 write to on/off bank spares blink bank, and vice versa
    wr(0, 5, 8'hff);
    check_vectors("R3 onoff write");
    wr(1, 31, 8'h00);
    check_vectors("R3 blink write");
    wr(0, 0, 8'h81);
    check_vectors("R1 addr0");

    // R8 mod_en toggles alter nothing
    for (int t = 0; t < 3; t++) begin
      @(negedge clk); mod_en = ~mod_en;
      @(negedge clk);
      check_vectors("R8 enable toggle");
    end

    // R7 frontplane gating sweeps
    mod_en = 1;
    fp_en = '1;          check_drive("R7 all");
    fp_en = 32'h5555_5555; check_drive("R7 alt");
    fp_en = 32'hAAAA_AAAA; check_drive("R7 alt2");
    for (int k = 0; k < NFP; k += 7) begin
      fp_en = NFP'(1) << k; check_drive("R7 onehot");
    end
    fp_en = '1; mod_en = 0; check_drive("R7 module off");
    mod_en = 1;

    // R5/R6 clear blink bank with concurrent write: on/off bank intact
    do_clear(1, 9, 8'h3c);
    check_vectors("R5 R6 clear blink");
    check_reads("R5 readback");
    check_drive("R7 after blink clear");
    // R5/R6 clear on/off bank
    do_clear(0, 2, 8'hc3);
    check_vectors("R5 R6 clear onoff");
    check_drive("R7 after onoff clear");
    wr(0, 2, 8'h5a);
    check_vectors("R1 after clear");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule